// File: doc/BRIEF.md
# Two-Line Interrupt Flag Aggregator

This block gathers a vector of event conditions into a sticky flag register and drives two interrupt lines from it. A flag is captured on the low-to-high transition of its condition, not on its level, and it stays captured until the host writes a 1 to its bit position. A mask register decides which flags may interrupt at all, a steering register sends each unmasked flag to line 0 or line 1, and a two-bit line-enable register switches each line on or off as a whole.

The host reaches the four registers through a plain word-wide read/write port: a write strobe with an address and data, and a combinational read data bus selected by the same address. The interrupt outputs are registered, so they follow the flag, mask, steering and line-enable state with one clock of latency. The event sources are outside this block.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset the flag register (address 0), mask register (address 1), steering register (address 2) and line-enable register (address 3) all read 0, and both interrupt outputs are 0.
- R2: A flag bit is set on the clock edge that first samples its condition high after having sampled it low; a condition that simply stays high does not set the flag again once it has been cleared.
- R3: A set flag stays set after its condition returns low, until it is cleared by the host.
- R4: Writing address 0 clears every flag whose data bit is 1; flags whose data bit is 0 keep their value.
- R5: When a rising edge and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R6: A flag can only contribute to an interrupt line when its bit in the mask register (address 1) is 1.
- R7: A masked-in flag goes to line 0 when its bit in the steering register (address 2) is 0, and to line 1 when that bit is 1.
- R8: Bit 0 of the line-enable register (address 3) gates line 0 and bit 1 gates line 1; a line whose bit is 0 stays low whatever the flags.
- R9: Each interrupt output equals the OR over flags that are set, masked in and steered to that line, ANDed with its line-enable bit, as computed from the register state of the previous clock cycle.
- R10: Mask, steering and line-enable registers read back exactly what was last written to them (line-enable zero-extended), and address 0 reads the current flag vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | Event conditions, one per flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 flags, 1 mask, 2 steering, 3 line enable) |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data for addr_i |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
The bench targets a condition held high across a clear, which a level-sensitive design would re-flag at once, and a simultaneous edge and clearing write on one bit, where a clear-wins design would lose the event. It checks that writing zeros to the flag address leaves flags alone, which a plain-write design would break by wiping them. It walks mask, steering and line-enable combinations at the top and bottom bit positions, catching an inverted steering sense or swapped line-enable bits, and it samples the output the cycle before and after a flag change to catch a combinational or two-stage output path.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NLINES = 2;
  localparam int AW     = 2;

  typedef enum logic [AW-1:0] {
    REG_FLAG  = 2'd0,
    REG_MASK  = 2'd1,
    REG_STEER = 2'd2,
    REG_LINE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cond_i;
  end

  assign rise_o = cond_i & ~prev_q;
endmodule

// File: rtl/irqagg_flags.sv
module irqagg_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  // set has priority over clear for the same bit
  function automatic logic [W-1:0] next_flags(input logic [W-1:0] cur,
                                               input logic [W-1:0] set,
                                               input logic [W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  logic [W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, rise_i, clr_i);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route #(
  parameter int W      = 32,
  parameter int NLINES = 2
) (
  input  logic [W-1:0]      flags_i,
  input  logic [W-1:0]      mask_i,
  input  logic [W-1:0]      steer_i,
  input  logic [NLINES-1:0] line_en_i,
  output logic [NLINES-1:0] line_o
);
  function automatic logic line_hit(input logic [W-1:0] fl,
                                    input logic [W-1:0] mk,
                                    input logic [W-1:0] to_line,
                                    input logic         gate);
    return gate & (|(fl & mk & to_line));
  endfunction

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [W-1:0] to_line;
    if (l == 0) begin : g_l0
      assign to_line = ~steer_i;
    end else begin : g_l1
      assign to_line = steer_i;
    end
    assign line_o[l] = line_hit(flags_i, mask_i, to_line, line_en_i[l]);
  end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import irqagg_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en_i,
  input  logic [1:0]      addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq0_o,
  output logic            irq1_o
);
  localparam int PADW = NSRC - NLINES;

  logic [NSRC-1:0]   rise_w;
  logic [NSRC-1:0]   clr_w;
  logic [NSRC-1:0]   flags_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   steer_q;
  logic [NLINES-1:0] line_en_q;
  logic [NLINES-1:0] line_w;
  logic [NLINES-1:0] irq_q;
  reg_sel_e          sel_w;

  assign sel_w = reg_sel_e'(addr_i);
  assign clr_w = (wr_en_i && sel_w == REG_FLAG) ? wdata_i : '0;

  irqagg_edge #(.W(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (evt_i),
    .rise_o (rise_w)
  );

  irqagg_flags #(.W(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise_w),
    .clr_i   (clr_w),
    .flags_o (flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      steer_q   <= '0;
      line_en_q <= '0;
    end else if (wr_en_i) begin
      case (sel_w)
        REG_MASK:  mask_q    <= wdata_i;
        REG_STEER: steer_q   <= wdata_i;
        REG_LINE:  line_en_q <= wdata_i[NLINES-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel_w)
      REG_FLAG:  rdata_o = flags_q;
      REG_MASK:  rdata_o = mask_q;
      REG_STEER: rdata_o = steer_q;
      default:   rdata_o = {{PADW{1'b0}}, line_en_q};
    endcase
  end

  irqagg_route #(.W(NSRC), .NLINES(NLINES)) u_route (
    .flags_i   (flags_q),
    .mask_i    (mask_q),
    .steer_i   (steer_q),
    .line_en_i (line_en_q),
    .line_o    (line_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_w;
  end

  assign irq0_o = irq_q[0];
  assign irq1_o = irq_q[1];
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] rise_w,
  input logic [NSRC-1:0] clr_w,
  input logic [NSRC-1:0] flags_q,
  input logic [1:0]      line_w,
  input logic [1:0]      line_en_q,
  input logic            irq0_o,
  input logic            irq1_o
);
  // R2 and R5: every detected edge leaves its flag set, even under a clear
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((flags_q & $past(rise_w)) == $past(rise_w)));

  // R3: set flags not being cleared stay set
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_w)) == $past(flags_q & ~clr_w)));

  // R4: cleared bits without a concurrent edge drop
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(clr_w & ~rise_w)) == '0));

  // R2: no flag appears without an edge
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(rise_w)) == '0));

  // R8: a disabled line stays low next cycle
  p_line0_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en_q[0] |=> !irq0_o);
  p_line1_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en_q[1] |=> !irq1_o);

  // R9: outputs follow the routed state one cycle later
  p_irq0_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq0_o == $past(line_w[0])));
  p_irq1_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq1_o == $past(line_w[1])));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise_w    (rise_w),
  .clr_w     (clr_w),
  .flags_q   (flags_q),
  .line_w    (line_w),
  .line_en_q (line_en_q),
  .irq0_o    (irq0_o),
  .irq1_o    (irq1_o)
);

// File: tb/evt_irq_agg_tb.sv
module evt_irq_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int NV = 10;

  // stimulus: pulsed event pattern, mask, steering, line enable; expected irq0/irq1
  localparam logic [N-1:0] V_PAT   [NV] = '{32'h1, 32'h1, 32'h1, 32'h8000_0000, 32'h8000_0000,
                                            32'h00F0, 32'h00F0, 32'h0300, 32'h0300, 32'h0300};
  localparam logic [N-1:0] V_MASK  [NV] = '{32'h1, 32'h1, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'h0010, 32'h0F00, 32'h0100, 32'h0300, 32'h0300};
  localparam logic [N-1:0] V_STEER [NV] = '{32'h0, 32'h1, 32'h0, 32'h8000_0000, 32'h8000_0000,
                                            32'h0000, 32'hFFFF, 32'h0200, 32'h0200, 32'h0200};
  localparam logic [1:0]   V_LE    [NV] = '{2'd3, 2'd3, 2'd3, 2'd1, 2'd2, 2'd1, 2'd3, 2'd3, 2'd3, 2'd0};
  localparam logic         V_E0    [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic         V_E1    [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq0, irq1;
  int            checks = 0;
  int            errors = 0;
  logic [N-1:0]  rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_agg #(.NSRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    evt = p;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while still in reset
    rd(2'd0, rv); check("R1 flags", rv, '0);
    rd(2'd1, rv); check("R1 mask", rv, '0);
    rd(2'd2, rv); check("R1 steer", rv, '0);
    rd(2'd3, rv); check("R1 line", rv, '0);
    check("R1 irq", {irq1, irq0}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 readback
    wr(2'd1, 32'hA5A5_5A5A); rd(2'd1, rv); check("R10 mask", rv, 32'hA5A5_5A5A);
    wr(2'd2, 32'h1234_8765); rd(2'd2, rv); check("R10 steer", rv, 32'h1234_8765);
    wr(2'd3, 32'hFFFF_FFFE); rd(2'd3, rv); check("R10 line", rv, 32'h2);

    // table walk: R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd3, 32'h0);
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, V_MASK[i]);
      wr(2'd2, V_STEER[i]);
      wr(2'd3, {30'h0, V_LE[i]});
      pulse(V_PAT[i]);
      rd(2'd0, rv); check($sformatf("R3 vec%0d flags", i), rv, V_PAT[i]);
      @(negedge clk);
      check($sformatf("R6 R7 R8 vec%0d irq0", i), irq0, V_E0[i]);
      check($sformatf("R6 R7 R8 vec%0d irq1", i), irq1, V_E1[i]);
    end

    // R9 latency: flag set visible, irq one cycle later
    wr(2'd3, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h4);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h1);
    @(negedge clk);
    pulse(32'h4);
    rd(2'd0, rv); check("R9 flag now", rv, 32'h4);
    check("R9 irq0 not yet", irq0, 1'b0);
    @(negedge clk);
    check("R9 irq0 after one", irq0, 1'b1);
    wr(2'd0, 32'h4);
    check("R9 irq0 still", irq0, 1'b1);
    @(negedge clk);
    check("R9 irq0 drops", irq0, 1'b0);

    // R2: held-high condition does not re-set after clear
    wr(2'd0, 32'hFFFF_FFFF);
    evt = 32'h10;
    repeat (2) @(negedge clk);
    rd(2'd0, rv); check("R2 set by edge", rv, 32'h10);
    wr(2'd0, 32'h10);
    repeat (3) @(negedge clk);
    rd(2'd0, rv); check("R2 level no reset", rv, 32'h0);
    evt = '0;
    repeat (2) @(negedge clk);
    rd(2'd0, rv); check("R3 stays clear", rv, 32'h0);

    // R4: W1C, zeros no effect
    pulse(32'h3);
    wr(2'd0, 32'h0);
    rd(2'd0, rv); check("R4 write zero", rv, 32'h3);
    wr(2'd0, 32'h1);
    rd(2'd0, rv); check("R4 clear bit0", rv, 32'h2);

    // R5: edge and clear in same cycle on bit 5
    wr(2'd0, 32'hFFFF_FFFF);
    evt = 32'h20; wr_en = 1'b1; addr = 2'd0; wdata = 32'h20;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(2'd0, rv); check("R5 set wins", rv, 32'h20);

    finish_run();
  end
endmodule